// File: doc/BRIEF.md
# Indirect Register Window Bridge

The bridge gives a host a small window of four 32-bit registers through which it reaches a second, internal register space. To make an access, the host loads a target address and, for a write, a data word. It then writes a request into the command register. The bridge runs exactly one transfer on its internal register-bus master port and waits for the single-cycle response strobe. It then raises an acknowledge bit in the same command register. The host polls that register until the acknowledge appears, picks up read data if it asked for a read, and writes zero to the command register to finish.

The command state machine has three states. ST_IDLE waits for a request. ST_ISSUE holds the internal request until the response strobe arrives. ST_DONE holds the acknowledge. The named transitions are:
- ACCEPT: from ST_IDLE on a valid command.
- RESPOND: from ST_ISSUE to ST_DONE when the response strobe arrives.
- CLEAR: from ST_DONE to ST_IDLE when zero is written.
- RESTART: from ST_DONE back to ST_ISSUE when a new valid command arrives while a stale acknowledge is still set.

Top module: `rb_bridge`

## Requirements
- R1: After reset, all four registers read as 0, the state is ST_IDLE and `ib_req` is low.
- R2: Host word index 0 (byte 0x0) is the command register. Index 1 (0x4) holds the target address in its low AW bits and reads back zero-extended. Index 2 (0x8) is the read-only read-data register. Index 3 (0xC) holds the write data and reads back.
- R3: The command register reads {29'b0, ack, wr, rd}. Bit 0 is the accepted read request, bit 1 is the accepted write request, and bit 2 is the acknowledge.
- R4: Writing 2 (write request) starts one internal write. `ib_req` rises in the cycle after the command write, with `ib_we`=1. Address and data are the register values held when the command was written. They stay stable until `ib_rsp`, even if the host rewrites registers 1 or 3.
- R5: Writing 1 (read request) starts one internal read with `ib_we`=0. On the `ib_rsp` edge, `ib_rdata` is captured into register 2 and the acknowledge is set, so the read data is valid whenever the acknowledge reads 1.
- R6: The acknowledge stays set until the host writes 0 to index 0. After that write the command register reads exactly 0.
- R7: A command written while an access is in flight (ST_ISSUE) is ignored and does not start a second access.
- R8: A command word with both request bits set, or one that is non-zero but has neither request bit set, is ignored.
- R9: A valid command written in ST_DONE (stale acknowledge present) clears the acknowledge and starts a fresh access.
- R10: Register 2 keeps its value until the next completed read. Internal writes and host writes to index 2 leave it unchanged.
- R11: Writing 0 while an access is in flight is ignored. The access completes and acknowledges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hst_sel | input | 1 | Host access select |
| hst_wr | input | 1 | Host write (1) or read (0) |
| hst_widx | input | 2 | Host register word index (byte offset / 4) |
| hst_wdata | input | DW | Host write data |
| hst_rdata | output | DW | Host read data (combinational from index) |
| ib_req | output | 1 | Internal bus request, held until response |
| ib_we | output | 1 | Internal bus write enable |
| ib_addr | output | AW | Internal bus address |
| ib_wdata | output | DW | Internal bus write data |
| ib_rsp | input | 1 | Internal bus single-cycle response strobe |
| ib_rdata | input | DW | Internal bus read data, valid with ib_rsp |

## Verification
The hardest situations to reach are those where the host acts while a transfer is still open: a second command, or a premature clear, or register rewrites landing between request and response. A well-behaved slave answers too quickly for these to occur. The bench therefore stalls its slave model with an enable, performs those host writes while the request is held, and only then releases the slave. The stale-acknowledge restart is reached by leaving a completed read unacknowledged and writing a new command over it.

// File: rtl/rb_pkg.sv
package rb_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_DONE  = 2'd2
    } rb_state_e;

    localparam logic [1:0] IDX_CMD   = 2'd0;
    localparam logic [1:0] IDX_ADDR  = 2'd1;
    localparam logic [1:0] IDX_RDAT  = 2'd2;
    localparam logic [1:0] IDX_WDAT  = 2'd3;

    localparam int CMD_RD_BIT  = 0;
    localparam int CMD_WR_BIT  = 1;
    localparam int CMD_ACK_BIT = 2;
    localparam int CMD_BITS    = 3;
endpackage

// File: rtl/rb_regs.sv
module rb_regs #(
    parameter int AW = 16,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [1:0]    widx,
    input  logic [DW-1:0] wdata,
    output logic [AW-1:0] addr_q,
    output logic [DW-1:0] wdat_q
);
    import rb_pkg::*;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            wdat_q <= '0;
        end else if (wr_en) begin
            if (widx == IDX_ADDR) addr_q <= wdata[AW-1:0];
            if (widx == IDX_WDAT) wdat_q <= wdata;
        end
    end
endmodule

// File: rtl/rb_fsm.sv
module rb_fsm #(
    parameter int AW = 16,
    parameter int DW = 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cmd_wr,
    input  logic [DW-1:0]                cmd_val,
    input  logic [AW-1:0]                addr_q,
    input  logic [DW-1:0]                wdat_q,
    input  logic                         ib_rsp,
    input  logic [DW-1:0]                ib_rdata,
    output logic                         ib_req,
    output logic                         ib_we,
    output logic [AW-1:0]                ib_addr,
    output logic [DW-1:0]                ib_wdata,
    output logic [rb_pkg::CMD_BITS-1:0]  cmd_word,
    output logic [DW-1:0]                rd_data
);
    import rb_pkg::*;

    rb_state_e state_q, state_d;
    logic      op_rd_q, op_wr_q;
    logic      want_rd, want_wr, is_go, is_clr, accept, clear, respond;

    always_comb begin
        want_rd = cmd_val[CMD_RD_BIT] & ~cmd_val[CMD_WR_BIT];
        want_wr = cmd_val[CMD_WR_BIT] & ~cmd_val[CMD_RD_BIT];
        is_go   = want_rd | want_wr;
        is_clr  = (cmd_val == '0);
        accept  = cmd_wr & is_go & (state_q != ST_ISSUE);
        clear   = cmd_wr & is_clr & (state_q == ST_DONE);
        respond = (state_q == ST_ISSUE) & ib_rsp;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (accept) state_d = ST_ISSUE;
            ST_ISSUE: if (respond) state_d = ST_DONE;
            ST_DONE: begin
                if (accept)     state_d = ST_ISSUE;
                else if (clear) state_d = ST_IDLE;
            end
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_rd_q  <= 1'b0;
            op_wr_q  <= 1'b0;
            ib_we    <= 1'b0;
            ib_addr  <= '0;
            ib_wdata <= '0;
            rd_data  <= '0;
        end else begin
            if (accept) begin
                op_rd_q  <= want_rd;
                op_wr_q  <= want_wr;
                ib_we    <= want_wr;
                ib_addr  <= addr_q;
                ib_wdata <= wdat_q;
            end else if (clear) begin
                op_rd_q <= 1'b0;
                op_wr_q <= 1'b0;
            end
            if (respond && !ib_we) rd_data <= ib_rdata;
        end
    end

    always_comb begin
        ib_req   = (state_q == ST_ISSUE);
        cmd_word = '0;
        cmd_word[CMD_RD_BIT]  = op_rd_q;
        cmd_word[CMD_WR_BIT]  = op_wr_q;
        cmd_word[CMD_ACK_BIT] = (state_q == ST_DONE);
    end
endmodule

// File: rtl/rb_bridge.sv
module rb_bridge #(
    parameter int AW = 16,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hst_sel,
    input  logic          hst_wr,
    input  logic [1:0]    hst_widx,
    input  logic [DW-1:0] hst_wdata,
    output logic [DW-1:0] hst_rdata,
    output logic          ib_req,
    output logic          ib_we,
    output logic [AW-1:0] ib_addr,
    output logic [DW-1:0] ib_wdata,
    input  logic          ib_rsp,
    input  logic [DW-1:0] ib_rdata
);
    import rb_pkg::*;

    localparam int ADDR_PAD = DW - AW;
    localparam int CMD_PAD  = DW - CMD_BITS;

    logic                host_wr_en;
    logic                cmd_wr;
    logic [AW-1:0]       addr_q;
    logic [DW-1:0]       wdat_q;
    logic [CMD_BITS-1:0] cmd_word;
    logic [DW-1:0]       rd_data;

    assign host_wr_en = hst_sel & hst_wr;
    assign cmd_wr     = host_wr_en & (hst_widx == IDX_CMD);

    rb_regs #(.AW(AW), .DW(DW)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (host_wr_en),
        .widx   (hst_widx),
        .wdata  (hst_wdata),
        .addr_q (addr_q),
        .wdat_q (wdat_q)
    );

    rb_fsm #(.AW(AW), .DW(DW)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_wr   (cmd_wr),
        .cmd_val  (hst_wdata),
        .addr_q   (addr_q),
        .wdat_q   (wdat_q),
        .ib_rsp   (ib_rsp),
        .ib_rdata (ib_rdata),
        .ib_req   (ib_req),
        .ib_we    (ib_we),
        .ib_addr  (ib_addr),
        .ib_wdata (ib_wdata),
        .cmd_word (cmd_word),
        .rd_data  (rd_data)
    );

    always_comb begin
        unique case (hst_widx)
            IDX_CMD:  hst_rdata = {{CMD_PAD{1'b0}}, cmd_word};
            IDX_ADDR: hst_rdata = {{ADDR_PAD{1'b0}}, addr_q};
            IDX_RDAT: hst_rdata = rd_data;
            IDX_WDAT: hst_rdata = wdat_q;
            default:  hst_rdata = '0;
        endcase
    end
endmodule

// File: rtl/rb_bridge_chk.sv
module rb_bridge_chk #(
    parameter int AW = 16,
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          hst_sel,
    input logic          hst_wr,
    input logic [1:0]    hst_widx,
    input logic [DW-1:0] hst_wdata,
    input logic          ib_req,
    input logic          ib_we,
    input logic [AW-1:0] ib_addr,
    input logic [DW-1:0] ib_wdata,
    input logic          ib_rsp,
    input logic [2:0]    cmd_word,
    input logic [DW-1:0] rd_data
);
    logic cmd_touch;
    assign cmd_touch = hst_sel & hst_wr & (hst_widx == 2'd0);

    // R4
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ib_req && !ib_rsp |=> ib_req);

    // R4
    req_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ib_req && !ib_rsp |=> $stable(ib_addr) && $stable(ib_we) && $stable(ib_wdata));

    // R5
    ack_after_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmd_word[2]) |-> $past(ib_rsp && ib_req));

    // R6
    ack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_word[2] && !cmd_touch |=> cmd_word[2]);

    // R8
    both_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_touch && hst_wdata[1:0] == 2'b11 && !ib_req |=> !ib_req);

    // R10
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ib_rsp && ib_req && !ib_we) |=> $stable(rd_data));
endmodule

bind rb_bridge rb_bridge_chk #(.AW(AW), .DW(DW)) u_chk (.*);

// File: tb/test_rb_bridge.sv
module test_rb_bridge;
    localparam int AW  = 16;
    localparam int DW  = 32;
    localparam int LAT = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          hst_sel = 1'b0;
    logic          hst_wr = 1'b0;
    logic [1:0]    hst_widx = 2'd0;
    logic [DW-1:0] hst_wdata = '0;
    logic [DW-1:0] hst_rdata;
    logic          ib_req, ib_we;
    logic [AW-1:0] ib_addr;
    logic [DW-1:0] ib_wdata;
    logic          ib_rsp = 1'b0;
    logic [DW-1:0] ib_rdata = '0;

    int checks = 0;
    int failures = 0;
    bit done = 0;
    bit slv_en = 1;
    int slv_cnt = 0;
    bit in_flight = 0;
    logic [DW+AW:0] exp_q[$];

    always #10 clk = ~clk;

    rb_bridge #(.AW(AW), .DW(DW)) i_rb_bridge (.*);

    function automatic logic [DW-1:0] model(input logic [AW-1:0] a);
        return {a ^ 16'hA5C3, a};
    endfunction

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic hwrite(input logic [1:0] idx, input logic [DW-1:0] d);
        @(negedge clk);
        hst_sel = 1; hst_wr = 1; hst_widx = idx; hst_wdata = d;
        @(negedge clk);
        hst_sel = 0; hst_wr = 0;
    endtask

    task automatic hread(input logic [1:0] idx, output logic [DW-1:0] d);
        hst_sel = 1; hst_wr = 0; hst_widx = idx;
        #1 d = hst_rdata;
        hst_sel = 0;
    endtask

    task automatic expect_bus(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] d);
        exp_q.push_back({we, a, d});
    endtask

    task automatic poll_ack(input string req);
        logic [DW-1:0] v;
        v = '0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            hread(2'd0, v);
            if (v[2]) break;
        end
        checks++;
        if (!v[2]) begin
            failures++;
            $display("FAIL %s ack never set actual=0x%08h expected=bit2", req, v);
        end
    endtask

    // slave model
    always @(negedge clk) begin
        if (ib_rsp) begin
            ib_rsp = 0; slv_cnt = 0;
        end else if (ib_req && slv_en) begin
            if (slv_cnt == LAT - 1) begin
                ib_rsp = 1; ib_rdata = model(ib_addr);
            end else slv_cnt++;
        end
    end

    // scoreboard monitor
    always @(negedge clk) begin
        if (!ib_req) in_flight = 0;
        else if (!in_flight) begin
            logic [DW+AW:0] e;
            in_flight = 1;
            checks++;
            if (exp_q.size() == 0) begin
                failures++;
                $display("FAIL R7 unexpected request actual=we%0d/0x%04h expected=none", ib_we, ib_addr);
            end else begin
                e = exp_q.pop_front();
                if (ib_we !== e[DW+AW] || ib_addr !== e[DW+AW-1:DW] ||
                    (e[DW+AW] && ib_wdata !== e[DW-1:0])) begin
                    failures++;
                    $display("FAIL R4/R5 bus actual=%0d/0x%04h/0x%08h expected=%0d/0x%04h/0x%08h",
                             ib_we, ib_addr, ib_wdata, e[DW+AW], e[DW+AW-1:DW], e[DW-1:0]);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1
        for (int i = 0; i < 4; i++) begin
            hread(i[1:0], v); chk("R1 reg reset", v, 0);
        end
        chk("R1 ib_req", {31'b0, ib_req}, 0);

        // R2 map
        hwrite(2'd1, 32'hFFFF_1234);
        hwrite(2'd3, 32'hDEAD_BEEF);
        hread(2'd1, v); chk("R2 addr readback", v, 32'h0000_1234);
        hread(2'd3, v); chk("R2 wdata readback", v, 32'hDEAD_BEEF);

        // R4 write access, host rewrites during flight
        expect_bus(1, 16'h1234, 32'hDEAD_BEEF);
        hwrite(2'd0, 32'd2);
        chk("R4 req rises", {31'b0, ib_req}, 1);
        hread(2'd0, v); chk("R3 cmd busy write", v, 32'd2);
        hwrite(2'd1, 32'h5555);
        chk("R4 addr held", {16'b0, ib_addr}, 32'h1234);
        poll_ack("R4");
        hread(2'd0, v); chk("R3 cmd write ack", v, 32'd6);
        repeat (10) @(negedge clk);
        hread(2'd0, v); chk("R6 ack held", v, 32'd6);
        hwrite(2'd0, 32'd0);
        hread(2'd0, v); chk("R6 cleared", v, 32'd0);

        // R5 read
        hwrite(2'd1, 32'h0042);
        expect_bus(0, 16'h0042, 0);
        hwrite(2'd0, 32'd1);
        poll_ack("R5");
        hread(2'd0, v); chk("R3 cmd read ack", v, 32'd5);
        hread(2'd2, v); chk("R5 read data", v, model(16'h0042));
        hwrite(2'd0, 32'd0);

        // R7 / R11 with stalled slave
        slv_en = 0;
        hwrite(2'd1, 32'h0077);
        expect_bus(0, 16'h0077, 0);
        hwrite(2'd0, 32'd1);
        hwrite(2'd0, 32'd2);
        hread(2'd0, v); chk("R7 busy cmd ignored", v, 32'd1);
        hwrite(2'd0, 32'd0);
        hread(2'd0, v); chk("R11 clear in flight ignored", v, 32'd1);
        slv_en = 1;
        poll_ack("R11");
        hread(2'd2, v); chk("R11 read completes", v, model(16'h0077));
        hwrite(2'd0, 32'd0);
        repeat (3) @(negedge clk);
        chk("R7 no second access", {31'b0, ib_req}, 0);

        // R8
        hwrite(2'd0, 32'd3);
        repeat (3) @(negedge clk);
        hread(2'd0, v); chk("R8 both bits ignored", v, 32'd0);
        chk("R8 no request", {31'b0, ib_req}, 0);
        hwrite(2'd0, 32'd4);
        repeat (3) @(negedge clk);
        hread(2'd0, v); chk("R8 no request bits ignored", v, 32'd0);

        // R10
        hwrite(2'd1, 32'h0010);
        hwrite(2'd3, 32'h0000_0001);
        expect_bus(1, 16'h0010, 32'h1);
        hwrite(2'd0, 32'd2);
        poll_ack("R10");
        hread(2'd2, v); chk("R10 write keeps rdata", v, model(16'h0077));
        hwrite(2'd2, 32'h0000_FFFF);
        hread(2'd2, v); chk("R10 host write ignored", v, model(16'h0077));
        hwrite(2'd0, 32'd0);

        // R9 stale ack restart
        hwrite(2'd1, 32'h0099);
        expect_bus(0, 16'h0099, 0);
        hwrite(2'd0, 32'd1);
        poll_ack("R9 first");
        hwrite(2'd1, 32'h009A);
        hwrite(2'd3, 32'hCAFE_0001);
        expect_bus(1, 16'h009A, 32'hCAFE_0001);
        hwrite(2'd0, 32'd2);
        hread(2'd0, v); chk("R9 ack dropped on restart", v, 32'd2);
        poll_ack("R9 second");
        hread(2'd0, v); chk("R9 restart acked", v, 32'd6);
        hwrite(2'd0, 32'd0);
        repeat (3) @(negedge clk);
        chk("R4 all expected accesses seen", exp_q.size(), 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule